// File: doc/BRIEF.md
# Timer Status Flags and Prescaler Reset Control

This block holds the status and control bits that sit beside an 8-bit timer/counter. It watches the counter's events and latches two sticky flags. The compare flag records that the counter matched its compare value. The overflow flag records that the counter wrapped. In up/down PWM mode the overflow flag instead records that the counter turned round at the bottom. Software clears a flag by writing a one to its bit. The interrupt controller clears a flag by acknowledging the matching vector. Each flag is gated with its own enable and the global interrupt enable to form an interrupt request.

A second register carries a prescaler-reset bit and a synchronization-mode bit. A one written to the prescaler-reset bit drives the prescaler reset output.
- When the timer runs synchronously, the bit drops by itself one cycle later.
- When the timer runs asynchronously, the bit stays high until the prescaler pulses its done input.
- While synchronization mode is set, hardware never drops the bit, so the prescaler stays in reset until software clears the mode bit.

The counter datapath and waveform logic live outside this block.

Top module: `timer_flag_ctrl`

## Requirements
- R1: On a cycle with `cnt_tick` high and `cnt_val` equal to `cmp_val`, the compare flag (flag register bit 1) reads one from the next cycle on.
- R2: With `updown_mode` low, a `cnt_wrap` pulse sets the overflow flag (flag register bit 0) on the next cycle.
- R3: With `updown_mode` high, the overflow flag sets on a `cnt_tick` with `cnt_val` equal to 0x00 and `cnt_down` high, and `cnt_wrap` is ignored.
- R4: A write to the flag register (`reg_addr`=0) clears each flag whose data bit is one; flag bits written with zero keep their value.
- R5: `ack_cmp` clears the compare flag and `ack_ovf` clears the overflow flag on the next cycle.
- R6: When a set event and a clear (write-one or acknowledge) reach the same flag in one cycle, the flag ends up set.
- R7: `irq_cmp` equals `gie & cmp_ie & compare flag`, and `irq_ovf` equals `gie & ovf_ie & overflow flag`.
- R8: Writing one to control bit 1 (`reg_addr`=1) raises the prescaler-reset bit and `pscl_rst`; with sync mode off and `async_mode` low, it returns to zero one cycle later. Writing zero to bit 1 has no effect.
- R9: With `async_mode` high and sync mode off, the prescaler-reset bit stays one until a cycle with `psr_done` high, after which it reads zero. `psr_done` is ignored while `async_mode` is low.
- R10: Control bit 7 is the sync-mode bit, written directly. While it is one, hardware does not clear the prescaler-reset bit.
- R11: Flag register bits 7:2 and control bits 6:2 and 0 always read zero. Reads, which are combinational on `reg_rdata`, change no state.
- R12: While `rst_n` is low at a clock edge, all flags, the sync-mode bit and the prescaler-reset bit become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter took a count step this cycle |
| cnt_val | input | 8 | Current counter value |
| cmp_val | input | 8 | Output-compare value |
| cnt_wrap | input | 1 | Counter wrapped (normal modes) |
| cnt_down | input | 1 | Counter is counting down |
| updown_mode | input | 1 | Up/down PWM mode selected |
| async_mode | input | 1 | Timer prescaler runs asynchronously |
| psr_done | input | 1 | Asynchronous prescaler finished its reset (single-cycle pulse) |
| gie | input | 1 | Global interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ack_cmp | input | 1 | Compare vector acknowledged |
| ack_ovf | input | 1 | Overflow vector acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flag register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| pscl_rst | output | 1 | Prescaler reset |

## Verification
Two situations are the hardest to reach from the ports.
- A set event colliding with both clearing paths for the same flag in one cycle. The bench builds such cycles on purpose: a matching tick together with an acknowledge and a write-one.
- The prescaler-reset bit waiting on an asynchronous done pulse while sync mode toggles around it. The bench holds `async_mode` high, fires `psr_done` both before and after the write, and sets and clears sync mode mid-wait.

Long runs of random traffic follow the directed cases, with mode changes biased to be rare, so that all the paths interleave. A behavioural model compares the outputs every cycle.

// File: rtl/timer_flag_ctrl.sv
module timer_flag_ctrl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_val,
  input  logic          cnt_wrap,
  input  logic          cnt_down,
  input  logic          updown_mode,
  input  logic          async_mode,
  input  logic          psr_done,
  input  logic          gie,
  input  logic          cmp_ie,
  input  logic          ovf_ie,
  input  logic          ack_cmp,
  input  logic          ack_ovf,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_cmp,
  output logic          irq_ovf,
  output logic          pscl_rst
);

  logic cmp_f, ovf_f, sync_q, psr_q;

  wire wr_flags = reg_wr && !reg_addr;
  wire wr_ctrl  = reg_wr &&  reg_addr;

  wire cmp_set = cnt_tick && (cnt_val == cmp_val);
  wire ovf_set = updown_mode ? (cnt_tick && cnt_val == '0 && cnt_down) : cnt_wrap;
  wire cmp_clr = ack_cmp || (wr_flags && reg_wdata[1]);
  wire ovf_clr = ack_ovf || (wr_flags && reg_wdata[0]);

  wire psr_auto_clr = !sync_q && (!async_mode || psr_done);

  logic unused_bits;
  assign unused_bits = &{1'b0, reg_wdata[6:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_f  <= 1'b0;
      ovf_f  <= 1'b0;
      sync_q <= 1'b0;
      psr_q  <= 1'b0;
    end else begin
      if (cmp_set)      cmp_f <= 1'b1;
      else if (cmp_clr) cmp_f <= 1'b0;
      if (ovf_set)      ovf_f <= 1'b1;
      else if (ovf_clr) ovf_f <= 1'b0;
      if (wr_ctrl) sync_q <= reg_wdata[7];
      if (wr_ctrl && reg_wdata[1]) psr_q <= 1'b1;
      else if (psr_auto_clr)       psr_q <= 1'b0;
    end
  end

  assign reg_rdata = reg_addr ? {sync_q, 5'b0, psr_q, 1'b0} : {6'b0, cmp_f, ovf_f};
  assign irq_cmp   = gie && cmp_ie && cmp_f;
  assign irq_ovf   = gie && ovf_ie && ovf_f;
  assign pscl_rst  = psr_q;

  // R1
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cnt_val == cmp_val) |=> cmp_f);

  // R2
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!updown_mode && cnt_wrap) |=> ovf_f);

  // R5
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cmp && !(cnt_tick && cnt_val == cmp_val)) |=> !cmp_f);

  // R8
  psr_self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q && !sync_q && !async_mode && !(reg_wr && reg_addr && reg_wdata[1])) |=> !psr_q);

  // R9
  psr_async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q && async_mode && !psr_done) |=> psr_q);

  // R10
  psr_sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q && sync_q) |=> psr_q);

  // R11
  flag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> reg_rdata[7:2] == 6'b0);

endmodule

// File: tb/tb_timer_flag_ctrl.sv
`timescale 1ns/1ps
module tb_timer_flag_ctrl;
  logic clk = 0, rst_n = 0;
  logic cnt_tick, cnt_wrap, cnt_down, updown_mode, async_mode, psr_done;
  logic gie, cmp_ie, ovf_ie, ack_cmp, ack_ovf, reg_wr, reg_addr;
  logic [7:0] cnt_val, cmp_val, reg_wdata, reg_rdata;
  logic irq_cmp, irq_ovf, pscl_rst;

  int checks = 0, errors = 0;
  bit m_cmp, m_ovf, m_sync, m_psr;

  always #2 clk = ~clk;

  timer_flag_ctrl dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    cnt_tick = 0; cnt_wrap = 0; cnt_down = 0; psr_done = 0;
    ack_cmp = 0; ack_ovf = 0; reg_wr = 0; reg_wdata = 0;
    cnt_val = 8'h55; cmp_val = 8'hAA;
  endtask

  task automatic step();
    bit s_c, s_o, c_c, c_o;
    @(posedge clk);
    if (!rst_n) begin
      m_cmp = 0; m_ovf = 0; m_sync = 0; m_psr = 0;
    end else begin
      s_c = cnt_tick && (cnt_val == cmp_val);
      s_o = updown_mode ? (cnt_tick && cnt_val == 0 && cnt_down) : cnt_wrap;
      c_c = ack_cmp || (reg_wr && !reg_addr && reg_wdata[1]);
      c_o = ack_ovf || (reg_wr && !reg_addr && reg_wdata[0]);
      m_cmp = s_c ? 1 : (c_c ? 0 : m_cmp);
      m_ovf = s_o ? 1 : (c_o ? 0 : m_ovf);
      if (reg_wr && reg_addr && reg_wdata[1]) m_psr = 1;
      else if (!m_sync && (!async_mode || psr_done)) m_psr = 0;
      if (reg_wr && reg_addr) m_sync = reg_wdata[7];
    end
    #1;
    if (reg_addr) chk("R8 R9 R10 R11 R12 control read", reg_rdata, {m_sync, 5'b0, m_psr, 1'b0});
    else          chk("R1 R2 R3 R4 R5 R6 R11 R12 flag read", reg_rdata, {6'b0, m_cmp, m_ovf});
    chk("R7 irq_cmp", irq_cmp, gie && cmp_ie && m_cmp);
    chk("R7 irq_ovf", irq_ovf, gie && ovf_ie && m_ovf);
    chk("R8 R9 R10 pscl_rst", pscl_rst, m_psr);
    idle();
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    updown_mode = 0; async_mode = 0; gie = 1; cmp_ie = 1; ovf_ie = 1; reg_addr = 0;
    step(); step();
    // R12 reset state seen on both registers
    reg_addr = 1; step();
    rst_n = 1; reg_addr = 0; step();
    // R1 compare match, R2 wrap
    cnt_tick = 1; cnt_val = 8'h3C; cmp_val = 8'h3C; step();
    cnt_wrap = 1; step();
    // R4 write zeros ignored, then write-one clears compare only
    wr(0, 8'h00); wr(0, 8'hFC); wr(0, 8'h02);
    // R5 acknowledge clears overflow
    ack_ovf = 1; step();
    // R6 set beats ack and write-one
    cnt_tick = 1; cnt_val = 8'h10; cmp_val = 8'h10; ack_cmp = 1;
    reg_wr = 1; reg_wdata = 8'h02; step();
    // R3 updown: wrap ignored, turn at bottom sets
    updown_mode = 1; wr(0, 8'h03);
    cnt_wrap = 1; step();
    cnt_tick = 1; cnt_val = 8'h00; cnt_down = 0; step();
    cnt_tick = 1; cnt_val = 8'h00; cnt_down = 1; step();
    updown_mode = 0;
    // R7 enables gate the requests
    gie = 0; step(); gie = 1; cmp_ie = 0; step(); cmp_ie = 1; ovf_ie = 0; step(); ovf_ie = 1;
    // R8 self-clearing prescaler reset, zero write ignored
    wr(1, 8'h02); reg_addr = 1; step(); wr(1, 8'h00);
    psr_done = 1; step();
    // R9 async hold until done
    async_mode = 1; wr(1, 8'h02); step(); step(); psr_done = 1; step(); step();
    // R10 sync mode holds, even with done
    wr(1, 8'h82); psr_done = 1; step(); step(); wr(1, 8'h00); step(); step();
    async_mode = 0;
    wr(1, 8'h82); step(); wr(1, 8'h00); step();
    // R11 reads have no side effect
    reg_addr = 0; step(); step();
    // random traffic
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 199) == 0) updown_mode = ~updown_mode;
      if ($urandom_range(0, 199) == 0) async_mode = ~async_mode;
      if ($urandom_range(0, 999) == 0) rst_n = 0; else rst_n = 1;
      gie = $urandom_range(0, 7) != 0; cmp_ie = $urandom; ovf_ie = $urandom;
      cnt_tick = $urandom; cnt_down = $urandom;
      cnt_val = $urandom_range(0, 3); cmp_val = $urandom_range(0, 3);
      cnt_wrap = $urandom_range(0, 7) == 0; psr_done = $urandom_range(0, 7) == 0;
      ack_cmp = $urandom_range(0, 5) == 0; ack_ovf = $urandom_range(0, 5) == 0;
      reg_addr = $urandom; reg_wr = $urandom_range(0, 5) == 0; reg_wdata = $urandom;
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule